// File: doc/BRIEF.md
# Register-access I2C transaction sequencer

This block sits above a byte-level I2C master engine and runs a whole register-style access without software stepping through bytes. A host gives it a 7-bit device address, a direction, and a byte count. A stored sub-address of zero to four bytes is loaded beforehand. The sequencer then sends the engine one command at a time and waits for each to complete. The sequence is the addressing byte, the sub-address bytes, an optional repeated start for reads, and the data bytes. Write data is taken from, and read data is put into, a small internal byte buffer that the host reaches through its own write and read ports.

Each request ends with a one-cycle `done` pulse, a status code, and the number of data bytes moved. A transfer ends early on bus contention, on an unanswered write, on lost arbitration, or when the engine goes silent. After a successful transfer the stored sub-address moves forward by the number of bytes moved, so the next access continues where the last one stopped.

Top module: `i2c_regseq`

## Requirements
- R1: After reset, `done`, `eng_cmd_valid` and `eng_enable` are low, and `status`, `xfer_len` and `sub_addr` are zero.
- R2: An accepted request first issues a command with start and write set and byte `{dev_addr, 1'b0}`.
- R3: The stored sub-address bytes follow as plain write commands, most significant byte first. A sub-address load with a length above 4 is ignored, and the stored value and length stay unchanged.
- R4: A write request sends its data bytes from buffer index 0 upward as plain writes. The last byte also carries stop. It then ends with status 0 (OK) and `xfer_len` equal to the byte count.
- R5: A read request issues start and write with byte `{dev_addr, 1'b1}` after the sub-address, then read commands. The last read carries stop and nack. Byte k received goes to buffer index k, and the request ends with status 0.
- R6: A NACK reported on a completed write command aborts the transfer when the request's ignore-NACK bit is clear. The block then issues one command with only stop set and ends with status 2 (NACK) and length 0. A NACK on a read command, or with ignore-NACK set, does not stop the transfer.
- R7: Lost arbitration ends the transfer at once with status 3 and length 0, and no further command is issued.
- R8: A request made while `bus_free` is low ends with status 1 (BUSY) and length 0, and no command is issued.
- R9: A request with length 0 or with the 10-bit flag set ends with status 5 (INVALID) and length 0, and no command is issued.
- R10: A transfer ending with status 0 adds its byte count to the stored sub-address. Any other status leaves the sub-address unchanged.
- R11: If the engine does not finish a command within `TIMEOUT_CYC` cycles, the request ends with status 4 (TIMEOUT) and length 0. `eng_enable` is low in the cycle of that `done`.
- R12: A request length above `BUF_DEPTH` is cut to `BUF_DEPTH`. That many bytes are transferred and reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | One-cycle request strobe |
| req_dev_addr | input | 7 | 7-bit device address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_len | input | REQ_LEN_W | Requested data byte count |
| req_ten_bit | input | 1 | 10-bit addressing flag (rejected) |
| req_ignore_nack | input | 1 | Do not abort on NACK |
| sub_load | input | 1 | Load the stored sub-address |
| sub_load_val | input | 32 | Sub-address value, right aligned |
| sub_load_len | input | 3 | Sub-address length in bytes |
| buf_we | input | 1 | Host buffer write strobe |
| buf_widx | input | IDX_W | Host buffer write index |
| buf_wdata | input | 8 | Host buffer write byte |
| buf_ridx | input | IDX_W | Host buffer read index |
| buf_rdata | output | 8 | Host buffer read byte |
| bus_free | input | 1 | Bus idle indication from the engine |
| eng_enable | output | 1 | Engine enable |
| eng_cmd_valid | output | 1 | Command strobe to the engine |
| eng_cmd_start | output | 1 | Command: generate start |
| eng_cmd_write | output | 1 | Command: write a byte |
| eng_cmd_read | output | 1 | Command: read a byte |
| eng_cmd_stop | output | 1 | Command: generate stop |
| eng_cmd_nack | output | 1 | Command: answer read with NACK |
| eng_tx_byte | output | 8 | Byte to write |
| eng_done | input | 1 | Engine finished the command |
| eng_nack | input | 1 | Slave did not acknowledge |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_rx_byte | input | 8 | Byte read |
| done | output | 1 | One-cycle end-of-request pulse |
| status | output | 3 | Result code |
| xfer_len | output | CNT_W | Data bytes transferred |
| sub_addr | output | 32 | Stored sub-address |

## Verification
The bench targets these corner cases:
- A NACK that lands on a sub-address byte must stop the transfer with a lone stop. A design that checks NACK on every command would wrongly abort reads, and one that ignores the ignore-NACK bit would abort when told not to.
- Sub-address byte order and zero-length sub-addresses are checked. A reversed shift sends the low byte first, and a missing repeated start merges the read into the write.
- Requests that must never reach the bus are covered: busy, zero length and 10-bit. A design that leaks a command here shows up as an unexpected command.
- Truncation and timeout are checked. A design with a wrong cut-off reports the wrong count or puts stop on the wrong byte, and one that loses the timeout hangs.

// File: rtl/i2c_regseq_pkg.sv
package i2c_regseq_pkg;

  typedef enum logic [2:0] {
    ST_OK      = 3'd0,
    ST_BUSY    = 3'd1,
    ST_NACK    = 3'd2,
    ST_ARB     = 3'd3,
    ST_TIMEOUT = 3'd4,
    ST_INVALID = 3'd5
  } status_e;

  typedef enum logic [1:0] {
    S_IDLE, S_WAIT, S_NEXT, S_NACKSTOP
  } fsm_e;

  typedef enum logic [2:0] {
    PH_ADDR, PH_SUB, PH_WDATA, PH_RSTART, PH_RDATA
  } phase_e;

  typedef struct packed {
    logic       start;
    logic       write;
    logic       read;
    logic       stop;
    logic       nack;
    logic [7:0] data;
  } cmd_t;

endpackage

// File: rtl/i2c_regseq_buf.sv
module i2c_regseq_buf #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             host_we,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [7:0]       host_wdata,
  input  logic             cap_we,
  input  logic [IDX_W-1:0] cap_idx,
  input  logic [7:0]       cap_data,
  input  logic [IDX_W-1:0] rd_idx_a,
  output logic [7:0]       rd_data_a,
  input  logic [IDX_W-1:0] rd_idx_b,
  output logic [7:0]       rd_data_b
);

  logic [7:0] mem_q [DEPTH];

  // capture from the bus takes priority over host writes
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    logic       en;
    logic [7:0] wd;
    always_comb begin
      en = 1'b0;
      wd = host_wdata;
      if (cap_we && cap_idx == IDX_W'(g)) begin
        en = 1'b1;
        wd = cap_data;
      end else if (host_we && host_idx == IDX_W'(g)) begin
        en = 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (en) mem_q[g] <= wd;
    end
  end

  assign rd_data_a = mem_q[rd_idx_a];
  assign rd_data_b = mem_q[rd_idx_b];

endmodule

// File: rtl/i2c_regseq_wdog.sv
module i2c_regseq_wdog #(
  parameter int LIMIT = 5000,
  localparam int CW = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expire
);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = '0;
    if (run && !expire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = run && (cnt_q == CW'(LIMIT - 1));

  a_r11_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT));

endmodule

// File: rtl/i2c_regseq_subreg.sv
module i2c_regseq_subreg #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_val,
  input  logic [2:0]       load_len,
  input  logic             busy,
  input  logic             inc_valid,
  input  logic [CNT_W-1:0] inc_amount,
  output logic [31:0]      sub_addr,
  output logic [2:0]       sub_len
);

  logic [31:0] addr_q, addr_d;
  logic [2:0]  len_q, len_d;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    if (inc_valid) begin
      addr_d = addr_q + 32'(inc_amount);
    end else if (load && !busy && load_len <= 3'd4) begin
      addr_d = load_val;
      len_d  = load_len;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
    end else begin
      addr_q <= addr_d;
      len_q  <= len_d;
    end
  end

  assign sub_addr = addr_q;
  assign sub_len  = len_q;

  a_r3_len_max: assert property (@(posedge clk) disable iff (!rst_n)
    len_q <= 3'd4);

endmodule

// File: rtl/i2c_regseq_fsm.sv
module i2c_regseq_fsm
  import i2c_regseq_pkg::*;
#(
  parameter int BUF_DEPTH = 16,
  parameter int REQ_LEN_W = 8,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [6:0]           req_dev_addr,
  input  logic                 req_read,
  input  logic [REQ_LEN_W-1:0] req_len,
  input  logic                 req_ten_bit,
  input  logic                 req_ignore_nack,
  input  logic                 bus_free,
  input  logic [31:0]          sub_addr,
  input  logic [2:0]           sub_len,
  input  logic                 wd_expire,
  output logic                 wd_run,
  input  logic                 eng_done,
  input  logic                 eng_nack,
  input  logic                 eng_arb_lost,
  input  logic [7:0]           eng_rx_byte,
  output logic [IDX_W-1:0]     buf_idx,
  input  logic [7:0]           buf_data,
  output logic                 cap_we,
  output logic [IDX_W-1:0]     cap_idx,
  output logic [7:0]           cap_data,
  output logic                 cmd_valid,
  output cmd_t                 cmd,
  output logic                 eng_enable,
  output logic                 busy,
  output logic                 done,
  output logic [2:0]           status,
  output logic [CNT_W-1:0]     xfer_len,
  output logic                 inc_valid,
  output logic [CNT_W-1:0]     inc_amount
);

  fsm_e       state_q, state_d;
  phase_e     phase_q, phase_d;
  logic [31:0] sh_q, sh_d;
  logic [2:0]  rem_q, rem_d;
  logic [CNT_W-1:0] idx_q, idx_d, len_q, len_d, xlen_q, xlen_d, eff_len;
  logic        rd_q, rd_d, ign_q, ign_d, lastwr_q, lastwr_d;
  logic [6:0]  addr_q, addr_d;
  logic        cmd_valid_q, cmd_valid_d, done_q, done_d, en_q, en_d;
  cmd_t        cmd_q, cmd_d;
  status_e     status_q, status_d;
  logic [5:0]  sh_amt;

  always_comb begin
    if (req_len > REQ_LEN_W'(BUF_DEPTH)) eff_len = CNT_W'(BUF_DEPTH);
    else                                 eff_len = CNT_W'(req_len);
    sh_amt = {(3'd4 - sub_len), 3'b000};
  end

  always_comb begin
    state_d = state_q;  phase_d = phase_q;  sh_d = sh_q;  rem_d = rem_q;
    idx_d = idx_q;  len_d = len_q;  rd_d = rd_q;  ign_d = ign_q;
    addr_d = addr_q;  lastwr_d = lastwr_q;  xlen_d = xlen_q;
    status_d = status_q;
    cmd_valid_d = 1'b0;  cmd_d = '0;  done_d = 1'b0;
    inc_valid = 1'b0;  cap_we = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_valid) begin
          if (req_ten_bit || req_len == '0) begin
            done_d = 1'b1;  status_d = ST_INVALID;  xlen_d = '0;
          end else if (!bus_free) begin
            done_d = 1'b1;  status_d = ST_BUSY;  xlen_d = '0;
          end else begin
            addr_d = req_dev_addr;  rd_d = req_read;  ign_d = req_ignore_nack;
            len_d = eff_len;  idx_d = '0;  rem_d = sub_len;
            sh_d = sub_addr << sh_amt;  phase_d = PH_ADDR;  lastwr_d = 1'b1;
            cmd_valid_d = 1'b1;  cmd_d.start = 1'b1;  cmd_d.write = 1'b1;
            cmd_d.data = {req_dev_addr, 1'b0};
            state_d = S_WAIT;
          end
        end
      end
      S_WAIT: begin
        if (eng_done) begin
          if (eng_arb_lost) begin
            done_d = 1'b1;  status_d = ST_ARB;  xlen_d = '0;  state_d = S_IDLE;
          end else if (eng_nack && lastwr_q && !ign_q) begin
            state_d = S_NACKSTOP;
          end else begin
            cap_we  = (phase_q == PH_RDATA);
            state_d = S_NEXT;
          end
        end else if (wd_expire) begin
          done_d = 1'b1;  status_d = ST_TIMEOUT;  xlen_d = '0;  state_d = S_IDLE;
        end
      end
      S_NACKSTOP: begin
        cmd_valid_d = 1'b1;  cmd_d.stop = 1'b1;
        done_d = 1'b1;  status_d = ST_NACK;  xlen_d = '0;  state_d = S_IDLE;
      end
      S_NEXT: begin
        state_d = S_WAIT;
        if (rem_q != 3'd0) begin
          cmd_valid_d = 1'b1;  cmd_d.write = 1'b1;  cmd_d.data = sh_q[31:24];
          sh_d = sh_q << 8;  rem_d = rem_q - 1'b1;  phase_d = PH_SUB;  lastwr_d = 1'b1;
        end else if (rd_q && phase_q != PH_RSTART && phase_q != PH_RDATA) begin
          cmd_valid_d = 1'b1;  cmd_d.start = 1'b1;  cmd_d.write = 1'b1;
          cmd_d.data = {addr_q, 1'b1};  phase_d = PH_RSTART;  lastwr_d = 1'b1;
        end else if (idx_q < len_q) begin
          cmd_valid_d = 1'b1;
          if (rd_q) begin
            cmd_d.read = 1'b1;
            cmd_d.stop = (idx_q == len_q - 1'b1);
            cmd_d.nack = (idx_q == len_q - 1'b1);
            phase_d = PH_RDATA;  lastwr_d = 1'b0;
          end else begin
            cmd_d.write = 1'b1;
            cmd_d.stop  = (idx_q == len_q - 1'b1);
            cmd_d.data  = buf_data;
            phase_d = PH_WDATA;  lastwr_d = 1'b1;
          end
          idx_d = idx_q + 1'b1;
        end else begin
          done_d = 1'b1;  status_d = ST_OK;  xlen_d = len_q;
          inc_valid = 1'b1;  state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
    en_d = (state_d != S_IDLE) || cmd_valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  phase_q <= PH_ADDR;  sh_q <= '0;  rem_q <= '0;
      idx_q <= '0;  len_q <= '0;  rd_q <= 1'b0;  ign_q <= 1'b0;
      addr_q <= '0;  lastwr_q <= 1'b0;  xlen_q <= '0;  status_q <= ST_OK;
      cmd_valid_q <= 1'b0;  cmd_q <= '0;  done_q <= 1'b0;  en_q <= 1'b0;
    end else begin
      state_q <= state_d;  phase_q <= phase_d;  sh_q <= sh_d;  rem_q <= rem_d;
      idx_q <= idx_d;  len_q <= len_d;  rd_q <= rd_d;  ign_q <= ign_d;
      addr_q <= addr_d;  lastwr_q <= lastwr_d;  xlen_q <= xlen_d;  status_q <= status_d;
      cmd_valid_q <= cmd_valid_d;  cmd_q <= cmd_d;  done_q <= done_d;  en_q <= en_d;
    end
  end

  assign wd_run     = (state_q == S_WAIT);
  assign busy       = (state_q != S_IDLE);
  assign buf_idx    = idx_q[IDX_W-1:0];
  assign cap_idx    = IDX_W'(idx_q - 1'b1);
  assign cap_data   = eng_rx_byte;
  assign cmd_valid  = cmd_valid_q;
  assign cmd        = cmd_q;
  assign eng_enable = en_q;
  assign done       = done_q;
  assign status     = status_q;
  assign xfer_len   = xlen_q;
  assign inc_amount = len_q;

  a_r2_first_start: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_q && !$past(en_q)) |-> (cmd_q.start && cmd_q.write && !cmd_q.data[0]));
  a_r4_cmd_excl: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_q |-> !(cmd_q.write && cmd_q.read));
  a_r6_nack_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_NACKSTOP) |=> (cmd_valid_q && cmd_q.stop && !cmd_q.write &&
                                 !cmd_q.read && done_q && status_q == ST_NACK));
  a_r7_arb_no_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT && eng_done && eng_arb_lost) |=>
      (done_q && status_q == ST_ARB && !cmd_valid_q));
  a_r8_reject_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && (status_q == ST_BUSY || status_q == ST_INVALID)) |-> !cmd_valid_q);
  a_r11_timeout_len: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && status_q == ST_TIMEOUT) |-> (xlen_q == '0 && !en_q));
  a_r12_len_cap: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (xlen_q <= CNT_W'(BUF_DEPTH)));

endmodule

// File: rtl/i2c_regseq.sv
module i2c_regseq
  import i2c_regseq_pkg::*;
#(
  parameter int BUF_DEPTH   = 16,
  parameter int REQ_LEN_W   = 8,
  parameter int TIMEOUT_CYC = 5000,
  localparam int IDX_W = $clog2(BUF_DEPTH),
  localparam int CNT_W = $clog2(BUF_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [6:0]           req_dev_addr,
  input  logic                 req_read,
  input  logic [REQ_LEN_W-1:0] req_len,
  input  logic                 req_ten_bit,
  input  logic                 req_ignore_nack,
  input  logic                 sub_load,
  input  logic [31:0]          sub_load_val,
  input  logic [2:0]           sub_load_len,
  input  logic                 buf_we,
  input  logic [IDX_W-1:0]     buf_widx,
  input  logic [7:0]           buf_wdata,
  input  logic [IDX_W-1:0]     buf_ridx,
  output logic [7:0]           buf_rdata,
  input  logic                 bus_free,
  output logic                 eng_enable,
  output logic                 eng_cmd_valid,
  output logic                 eng_cmd_start,
  output logic                 eng_cmd_write,
  output logic                 eng_cmd_read,
  output logic                 eng_cmd_stop,
  output logic                 eng_cmd_nack,
  output logic [7:0]           eng_tx_byte,
  input  logic                 eng_done,
  input  logic                 eng_nack,
  input  logic                 eng_arb_lost,
  input  logic [7:0]           eng_rx_byte,
  output logic                 done,
  output logic [2:0]           status,
  output logic [CNT_W-1:0]     xfer_len,
  output logic [31:0]          sub_addr
);

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic             wd_run, wd_expire, busy, cap_we, inc_valid;
  logic [IDX_W-1:0] fsm_idx, cap_idx;
  logic [7:0]       fsm_data, cap_data;
  logic [2:0]       sub_len;
  logic [CNT_W-1:0] inc_amount;
  cmd_t             cmd;

  i2c_regseq_buf #(.DEPTH(BUF_DEPTH)) u_buf (
    .clk(clk), .host_we(buf_we), .host_idx(buf_widx), .host_wdata(buf_wdata),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .rd_idx_a(fsm_idx), .rd_data_a(fsm_data),
    .rd_idx_b(buf_ridx), .rd_data_b(buf_rdata)
  );

  i2c_regseq_wdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk(clk), .rst_n(rst_s2_q), .run(wd_run), .expire(wd_expire)
  );

  i2c_regseq_subreg #(.CNT_W(CNT_W)) u_sub (
    .clk(clk), .rst_n(rst_s2_q), .load(sub_load), .load_val(sub_load_val),
    .load_len(sub_load_len), .busy(busy), .inc_valid(inc_valid),
    .inc_amount(inc_amount), .sub_addr(sub_addr), .sub_len(sub_len)
  );

  i2c_regseq_fsm #(.BUF_DEPTH(BUF_DEPTH), .REQ_LEN_W(REQ_LEN_W)) u_fsm (
    .clk(clk), .rst_n(rst_s2_q),
    .req_valid(req_valid), .req_dev_addr(req_dev_addr), .req_read(req_read),
    .req_len(req_len), .req_ten_bit(req_ten_bit), .req_ignore_nack(req_ignore_nack),
    .bus_free(bus_free), .sub_addr(sub_addr), .sub_len(sub_len),
    .wd_expire(wd_expire), .wd_run(wd_run),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb_lost(eng_arb_lost),
    .eng_rx_byte(eng_rx_byte), .buf_idx(fsm_idx), .buf_data(fsm_data),
    .cap_we(cap_we), .cap_idx(cap_idx), .cap_data(cap_data),
    .cmd_valid(eng_cmd_valid), .cmd(cmd), .eng_enable(eng_enable), .busy(busy),
    .done(done), .status(status), .xfer_len(xfer_len),
    .inc_valid(inc_valid), .inc_amount(inc_amount)
  );

  assign eng_cmd_start = cmd.start;
  assign eng_cmd_write = cmd.write;
  assign eng_cmd_read  = cmd.read;
  assign eng_cmd_stop  = cmd.stop;
  assign eng_cmd_nack  = cmd.nack;
  assign eng_tx_byte   = cmd.data;

endmodule

// File: tb/i2c_regseq_tb.sv
module i2c_regseq_tb;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, req_valid, req_read, req_ten_bit, req_ignore_nack;
  logic [6:0] req_dev_addr;
  logic [7:0] req_len;
  logic sub_load; logic [31:0] sub_load_val; logic [2:0] sub_load_len;
  logic buf_we; logic [3:0] buf_widx, buf_ridx; logic [7:0] buf_wdata, buf_rdata;
  logic bus_free, eng_enable, eng_cmd_valid, eng_cmd_start, eng_cmd_write;
  logic eng_cmd_read, eng_cmd_stop, eng_cmd_nack; logic [7:0] eng_tx_byte;
  logic eng_done, eng_nack, eng_arb_lost; logic [7:0] eng_rx_byte;
  logic done; logic [2:0] status; logic [4:0] xfer_len; logic [31:0] sub_addr;

  i2c_regseq u_dut (.*);

  int checks = 0, errors = 0, res_seen = 0, cyc = 0;
  string tag = "R1";
  logic [12:0] exp_cmd[$];
  logic [7:0]  exp_res[$];
  int nack_at = -1, arb_at = -1, rcount = 0, pend = 0;
  bit hang = 0;
  logic [31:0] bsub = 0;
  int bsublen = 0;

  task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic ecmd(bit s, bit w, bit r, bit p, bit n, logic [7:0] d);
    exp_cmd.push_back({s, w, r, p, n, d});
  endtask

  task automatic esub();
    for (int i = bsublen - 1; i >= 0; i--) ecmd(0, 1, 0, 0, 0, bsub[8*i +: 8]);
  endtask

  // engine model: answers read/write commands three cycles later
  initial begin
    eng_done = 0; eng_nack = 0; eng_arb_lost = 0; eng_rx_byte = 0;
    forever begin
      @(negedge clk);
      eng_done = 0; eng_nack = 0; eng_arb_lost = 0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          eng_done = 1;
          eng_nack = (rcount - 1 == nack_at);
          eng_arb_lost = (rcount - 1 == arb_at);
          eng_rx_byte = 8'hA0 + 8'(rcount - 1);
        end
      end
      if (rst_n && eng_cmd_valid && (eng_cmd_write || eng_cmd_read)) begin
        if (!hang) pend = 3;
        rcount++;
      end
    end
  end

  // monitor: compares commands and results against the scoreboard queues
  initial forever begin
    @(negedge clk);
    if (rst_n && eng_cmd_valid) begin
      if (exp_cmd.size() == 0)
        chk({tag, " unexpected command"}, {eng_cmd_start, eng_cmd_write, eng_cmd_read,
            eng_cmd_stop, eng_cmd_nack, eng_tx_byte}, 64'hDEAD);
      else
        chk({tag, " command"}, {eng_cmd_start, eng_cmd_write, eng_cmd_read,
            eng_cmd_stop, eng_cmd_nack, eng_tx_byte}, exp_cmd.pop_front());
    end
    if (rst_n && done) begin
      chk({tag, " status/len"}, {status, xfer_len},
          exp_res.size() ? exp_res.pop_front() : 8'hFF);
      chk({tag, " all commands seen"}, exp_cmd.size(), 0);
      res_seen++;
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errors++; checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  task automatic run(string t, bit rd, logic [6:0] a, logic [7:0] len, bit ten,
                     bit ign, logic [2:0] st, logic [4:0] xl);
    int target;
    tag = t; rcount = 0;
    exp_res.push_back({st, xl});
    target = res_seen + 1;
    @(negedge clk);
    req_valid = 1; req_read = rd; req_dev_addr = a; req_len = len;
    req_ten_bit = ten; req_ignore_nack = ign;
    @(negedge clk);
    req_valid = 0;
    while (res_seen < target) @(negedge clk);
    nack_at = -1; arb_at = -1; hang = 0;
  endtask

  task automatic load_sub(logic [31:0] v, logic [2:0] l);
    @(negedge clk);
    sub_load = 1; sub_load_val = v; sub_load_len = l;
    @(negedge clk);
    sub_load = 0;
    if (l <= 4) begin bsub = v; bsublen = int'(l); end
  endtask

  task automatic fill_buf();
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      buf_we = 1; buf_widx = 4'(i); buf_wdata = 8'h30 + 8'(i);
    end
    @(negedge clk);
    buf_we = 0;
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_read = 0; req_dev_addr = 0; req_len = 0;
    req_ten_bit = 0; req_ignore_nack = 0; sub_load = 0; sub_load_val = 0;
    sub_load_len = 0; buf_we = 0; buf_widx = 0; buf_wdata = 0; buf_ridx = 0;
    bus_free = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 done", done, 0); chk("R1 cmd_valid", eng_cmd_valid, 0);
    chk("R1 enable", eng_enable, 0); chk("R1 status", status, 0);
    chk("R1 len", xfer_len, 0); chk("R1 sub_addr", sub_addr, 0);

    fill_buf();
    load_sub(32'h1234, 3'd2);
    ecmd(1, 1, 0, 0, 0, 8'hA0); esub();
    ecmd(0, 1, 0, 0, 0, 8'h30); ecmd(0, 1, 0, 0, 0, 8'h31); ecmd(0, 1, 0, 1, 0, 8'h32);
    run("R2 R3 R4 write", 0, 7'h50, 8'd3, 0, 0, 3'd0, 5'd3);
    chk("R10 sub after write", sub_addr, 32'h1237);
    bsub = 32'h1237;

    load_sub(32'hAABBCCDD, 3'd5);
    chk("R3 long load ignored", sub_addr, 32'h1237);
    ecmd(1, 1, 0, 0, 0, 8'h42); esub(); ecmd(1, 1, 0, 0, 0, 8'h43);
    ecmd(0, 0, 1, 0, 0, 8'h00); ecmd(0, 0, 1, 1, 1, 8'h00);
    run("R5 read", 1, 7'h21, 8'd2, 0, 0, 3'd0, 5'd2);
    buf_ridx = 0; #1 chk("R5 rx byte0", buf_rdata, 8'hA4);
    buf_ridx = 1; #1 chk("R5 rx byte1", buf_rdata, 8'hA5);
    chk("R10 sub after read", sub_addr, 32'h1239);

    fill_buf();
    load_sub(32'h01020304, 3'd4);
    nack_at = 2;
    ecmd(1, 1, 0, 0, 0, 8'hA0); ecmd(0, 1, 0, 0, 0, 8'h01); ecmd(0, 1, 0, 0, 0, 8'h02);
    ecmd(0, 0, 0, 1, 0, 8'h00);
    run("R6 nack abort", 0, 7'h50, 8'd1, 0, 0, 3'd2, 5'd0);
    chk("R10 sub kept on nack", sub_addr, 32'h01020304);

    nack_at = 2;
    ecmd(1, 1, 0, 0, 0, 8'hA0); esub(); ecmd(0, 1, 0, 1, 0, 8'h30);
    run("R6 nack ignored", 0, 7'h50, 8'd1, 0, 1, 3'd0, 5'd1);
    chk("R10 sub 4-byte inc", sub_addr, 32'h01020305);

    load_sub(32'h0, 3'd0);
    nack_at = 2;
    ecmd(1, 1, 0, 0, 0, 8'h20); ecmd(1, 1, 0, 0, 0, 8'h21); ecmd(0, 0, 1, 1, 1, 8'h00);
    run("R6 R5 nack on read kept", 1, 7'h10, 8'd1, 0, 0, 3'd0, 5'd1);
    buf_ridx = 0; #1 chk("R5 rx no-sub", buf_rdata, 8'hA2);
    bsub = 32'h1;

    fill_buf();
    arb_at = 1;
    ecmd(1, 1, 0, 0, 0, 8'h66); ecmd(0, 1, 0, 0, 0, 8'h30);
    run("R7 arbitration", 0, 7'h33, 8'd2, 0, 0, 3'd3, 5'd0);
    chk("R10 sub kept on arb", sub_addr, 32'h1);

    bus_free = 0;
    run("R8 busy", 0, 7'h33, 8'd2, 0, 0, 3'd1, 5'd0);
    bus_free = 1;
    run("R9 zero length", 0, 7'h33, 8'd0, 0, 0, 3'd5, 5'd0);
    run("R9 ten bit", 1, 7'h33, 8'd2, 1, 0, 3'd5, 5'd0);
    chk("R10 sub kept on reject", sub_addr, 32'h1);

    ecmd(1, 1, 0, 0, 0, 8'hEE);
    for (int i = 0; i < 16; i++) ecmd(0, 1, 0, i == 15, 0, 8'h30 + 8'(i));
    run("R12 truncate", 0, 7'h77, 8'd20, 0, 0, 3'd0, 5'd16);
    chk("R12 sub by cut length", sub_addr, 32'h11);

    hang = 1;
    ecmd(1, 1, 0, 0, 0, 8'h18);
    fork
      run("R11 timeout", 0, 7'h0C, 8'd1, 0, 0, 3'd4, 5'd0);
      begin
        @(posedge done); @(negedge clk);
        chk("R11 enable low at done", eng_enable, 0);
      end
    join
    chk("R11 sub kept", sub_addr, 32'h11);

    repeat (5) @(negedge clk);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule